// File: doc/BRIEF.md
# Host and Coprocessor Mailbox

This block joins a host CPU and an audio coprocessor CPU through a set of byte registers. Both run on one clock. Each side sees its own small I/O space, and only the low 8 bits of its port address are decoded. The host posts commands and outbound data and collects inbound data. The coprocessor reads the command and the outbound data and returns data to the host. A host control port also pulses a reset or a non-maskable interrupt towards the coprocessor.

Two status flags tell each side whether a transfer is pending. Bit 7 is the data flag and bit 0 is the command flag. The flags change as side effects of port accesses on both sides. Two dedicated coprocessor ports load the flags from external inputs: bit 0 of the current page number, and bit 5 of the channel-0 volume. Read data is registered and appears on the clock after the read strobe.

Top module: `hcp_mailbox`

## Requirements
- R1: After reset, every register, both flags, both read-data outputs and both pulses are zero. A host status read then returns 0x7E and a coprocessor status read returns 0x00.
- R2: A host write to port 0xB3 loads the outbound byte and sets flag bit 7. A host write to port 0xBB loads the command byte and sets flag bit 0.
- R3: A host read of port 0xB3 returns the inbound byte and clears bit 7. A host read of port 0xBB returns the status with bits 6..1 forced to 1.
- R4: A host write to port 0x33 with data bit 7 set gives a one-cycle reset pulse. With bit 7 clear and bit 6 set, it gives a one-cycle interrupt pulse instead. The two pulses are never high together.
- R5: A coprocessor read of port 0x01 returns the command byte. A read of port 0x04 returns the raw status: bit 7 and bit 0 are the flags and bits 6..1 are 0.
- R6: A coprocessor read of port 0x02 returns the outbound byte and clears bit 7. A coprocessor write to port 0x02 also clears bit 7.
- R7: A coprocessor write to port 0x03 loads the inbound byte and sets bit 7. A coprocessor read of port 0x03 returns 0xFF, loads 0xFF as the inbound byte and sets bit 7.
- R8: Any coprocessor read or write of port 0x05 clears bit 0.
- R9: Any coprocessor access to port 0x0A copies page input bit 0 into bit 7. Any access to port 0x0B copies volume input bit 5 into bit 0.
- R10: Reads of any other port return 0xFF on either side. Address bits above bit 7 are ignored.
- R11: Read data appears on the clock after the read strobe and reflects the state before that cycle's side effects. It holds while no read is made.
- R12: When both sides change the same flag in one cycle, the coprocessor side's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | ADDR_W | Host port address |
| h_wdata | input | DATA_W | Host write data |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | DATA_W | Host read data, registered |
| c_addr | input | ADDR_W | Coprocessor port address |
| c_wdata | input | DATA_W | Coprocessor write data |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_rdata | output | DATA_W | Coprocessor read data, registered |
| page_in | input | DATA_W | Current page number from the coprocessor's paging logic |
| vol_in | input | VOL_W | Channel-0 volume value |
| core_rst_pulse | output | 1 | One-cycle coprocessor reset request |
| core_nmi_pulse | output | 1 | One-cycle coprocessor interrupt request |

## Verification
A flag update from the host side and a flag update from the coprocessor side can land in the same cycle. Examples are a host data write against a coprocessor data read, or a host command write against a coprocessor access to port 0x05 or 0x0B. The bench forces these pairs in directed cycles and also lets random traffic on both sides collide. The result is then read back through the coprocessor status port and compared with a model in which the coprocessor's effect is applied last.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned PORT_W = 8;

  // host side ports
  localparam logic [PORT_W-1:0] H_DATA = 8'hB3;
  localparam logic [PORT_W-1:0] H_CMD  = 8'hBB;
  localparam logic [PORT_W-1:0] H_CTRL = 8'h33;

  // coprocessor side ports
  localparam logic [PORT_W-1:0] C_CMD    = 8'h01;
  localparam logic [PORT_W-1:0] C_OUTB   = 8'h02;
  localparam logic [PORT_W-1:0] C_INB    = 8'h03;
  localparam logic [PORT_W-1:0] C_STAT   = 8'h04;
  localparam logic [PORT_W-1:0] C_CLRCMD = 8'h05;
  localparam logic [PORT_W-1:0] C_PAGE   = 8'h0A;
  localparam logic [PORT_W-1:0] C_VOL    = 8'h0B;

  // request to load one status flag
  typedef struct packed {
    logic we;
    logic val;
  } flag_req_t;
endpackage

// File: rtl/mbx_host_side.sv
module mbx_host_side
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              flag_d,
  input  logic              flag_c,
  input  logic [DATA_W-1:0] inb_q,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] outb_q,
  output flag_req_t         req_d,
  output flag_req_t         req_c,
  output logic              core_rst,
  output logic              core_nmi
);
  logic [PORT_W-1:0] port;
  logic [ADDR_W-1:0] unused_addr;
  logic              ctl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign port        = addr[PORT_W-1:0];
  assign unused_addr = addr;
  assign ctl_wr      = wr && (port == H_CTRL);

  always_comb begin
    req_d = '0;
    req_c = '0;
    if (rd && port == H_DATA) req_d = '{we: 1'b1, val: 1'b0};
    if (wr && port == H_DATA) req_d = '{we: 1'b1, val: 1'b1};
    if (wr && port == H_CMD)  req_c = '{we: 1'b1, val: 1'b1};
  end

  always_comb begin
    case (port)
      H_DATA:  rd_mux = inb_q;
      H_CMD:   rd_mux = {flag_d, {(DATA_W-2){1'b1}}, flag_c};
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      cmd_q    <= '0;
      outb_q   <= '0;
      core_rst <= 1'b0;
      core_nmi <= 1'b0;
    end else begin
      core_rst <= ctl_wr && wdata[DATA_W-1];
      core_nmi <= ctl_wr && !wdata[DATA_W-1] && wdata[DATA_W-2];
      if (wr && port == H_DATA) outb_q <= wdata;
      if (wr && port == H_CMD)  cmd_q  <= wdata;
      if (rd) rdata <= rd_mux;
    end
  end

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(core_rst && core_nmi));
  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[DATA_W-1]) |=> core_rst);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/mbx_cop_side.sv
module mbx_cop_side
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              page_bit,
  input  logic              vol_bit,
  input  logic [DATA_W-1:0] cmd_q,
  input  logic [DATA_W-1:0] outb_q,
  input  logic              flag_d,
  input  logic              flag_c,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] inb_q,
  output flag_req_t         req_d,
  output flag_req_t         req_c
);
  logic [PORT_W-1:0] port;
  logic [ADDR_W-1:0] unused_addr;
  logic              acc;
  logic [DATA_W-1:0] rd_mux;

  assign port        = addr[PORT_W-1:0];
  assign unused_addr = addr;
  assign acc         = wr || rd;

  always_comb begin
    req_d = '0;
    req_c = '0;
    if (acc) begin
      case (port)
        C_OUTB:  req_d = '{we: 1'b1, val: 1'b0};
        C_INB:   req_d = '{we: 1'b1, val: 1'b1};
        C_PAGE:  req_d = '{we: 1'b1, val: page_bit};
        C_CLRCMD: req_c = '{we: 1'b1, val: 1'b0};
        C_VOL:   req_c = '{we: 1'b1, val: vol_bit};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (port)
      C_CMD:   rd_mux = cmd_q;
      C_OUTB:  rd_mux = outb_q;
      C_STAT:  rd_mux = {flag_d, {(DATA_W-2){1'b0}}, flag_c};
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      inb_q <= '0;
    end else begin
      if (wr && port == C_INB)      inb_q <= wdata;
      else if (rd && port == C_INB) inb_q <= '1;
      if (rd) rdata <= rd_mux;
    end
  end

  // R7
  inb_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && port == C_INB) |=> (inb_q == $past(wdata)));
  // R7
  inb_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && port == C_INB) |=> (inb_q == '1));
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_req_t h_d,
  input  flag_req_t h_c,
  input  flag_req_t c_d,
  input  flag_req_t c_c,
  output logic      flag_d,
  output logic      flag_c
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      if (c_d.we)      flag_d <= c_d.val;
      else if (h_d.we) flag_d <= h_d.val;
      if (c_c.we)      flag_c <= c_c.val;
      else if (h_c.we) flag_c <= h_c.val;
    end
  end

  // R12
  cop_wins_d_chk: assert property (@(posedge clk) disable iff (rst)
    c_d.we |=> (flag_d == $past(c_d.val)));
  // R12
  cop_wins_c_chk: assert property (@(posedge clk) disable iff (rst)
    c_c.we |=> (flag_c == $past(c_c.val)));
  // R2
  host_set_d_chk: assert property (@(posedge clk) disable iff (rst)
    (h_d.we && h_d.val && !c_d.we) |=> flag_d);
  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!c_d.we && !h_d.we && !c_c.we && !h_c.we) |=> ($stable(flag_d) && $stable(flag_c)));
endmodule

// File: rtl/hcp_mailbox.sv
module hcp_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VOL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              h_wr,
  input  logic              h_rd,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  input  logic              c_wr,
  input  logic              c_rd,
  output logic [DATA_W-1:0] c_rdata,
  input  logic [DATA_W-1:0] page_in,
  input  logic [VOL_W-1:0]  vol_in,
  output logic              core_rst_pulse,
  output logic              core_nmi_pulse
);
  localparam int unsigned VOL_BIT = VOL_W - 1;

  logic [DATA_W-1:0] cmd_q, outb_q, inb_q;
  logic              flag_d, flag_c;
  flag_req_t         h_req_d, h_req_c, c_req_d, c_req_c;
  logic [DATA_W-1:0] unused_page;
  logic [VOL_W-1:0]  unused_vol;

  assign unused_page = page_in;
  assign unused_vol  = vol_in;

  mbx_host_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) host_i (
    .clk(clk), .rst(rst), .addr(h_addr), .wdata(h_wdata), .wr(h_wr), .rd(h_rd),
    .flag_d(flag_d), .flag_c(flag_c), .inb_q(inb_q), .rdata(h_rdata),
    .cmd_q(cmd_q), .outb_q(outb_q), .req_d(h_req_d), .req_c(h_req_c),
    .core_rst(core_rst_pulse), .core_nmi(core_nmi_pulse)
  );

  mbx_cop_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cop_i (
    .clk(clk), .rst(rst), .addr(c_addr), .wdata(c_wdata), .wr(c_wr), .rd(c_rd),
    .page_bit(page_in[0]), .vol_bit(vol_in[VOL_BIT]),
    .cmd_q(cmd_q), .outb_q(outb_q), .flag_d(flag_d), .flag_c(flag_c),
    .rdata(c_rdata), .inb_q(inb_q), .req_d(c_req_d), .req_c(c_req_c)
  );

  mbx_status stat_i (
    .clk(clk), .rst(rst), .h_d(h_req_d), .h_c(h_req_c),
    .c_d(c_req_d), .c_c(c_req_c), .flag_d(flag_d), .flag_c(flag_c)
  );
endmodule

// File: tb/hcp_mailbox_tb.sv
module hcp_mailbox_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OP_NONE = 0, OP_WR = 1, OP_RD = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] h_addr, c_addr;
  logic [7:0]  h_wdata, c_wdata, page_in;
  logic        h_wr, h_rd, c_wr, c_rd;
  logic [5:0]  vol_in;
  logic [7:0]  h_rdata, c_rdata;
  logic        core_rst_pulse, core_nmi_pulse;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_cmd, m_out, m_in, last_h, last_c;
  logic       m_d, m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcp_mailbox dut_i (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr), .h_rd(h_rd),
    .h_rdata(h_rdata), .c_addr(c_addr), .c_wdata(c_wdata), .c_wr(c_wr), .c_rd(c_rd),
    .c_rdata(c_rdata), .page_in(page_in), .vol_in(vol_in),
    .core_rst_pulse(core_rst_pulse), .core_nmi_pulse(core_nmi_pulse)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] host_exp(input logic [7:0] p);
    if (p == 8'hB3) return m_in;
    if (p == 8'hBB) return {m_d, 6'h3F, m_c};
    return 8'hFF;
  endfunction

  function automatic logic [7:0] cop_exp(input logic [7:0] p);
    case (p)
      8'h01: return m_cmd;
      8'h02: return m_out;
      8'h04: return {m_d, 6'h00, m_c};
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string host_tag(input logic [7:0] p);
    return (p == 8'hB3 || p == 8'hBB) ? "R3" : "R10";
  endfunction

  function automatic string cop_tag(input logic [7:0] p);
    case (p)
      8'h01, 8'h04: return "R5";
      8'h02: return "R6";
      8'h03: return "R7";
      default: return "R10";
    endcase
  endfunction

  // one clock with one operation per side; called just after a falling edge
  task automatic step(input int hop, input logic [15:0] ha, input logic [7:0] hw,
                      input int cop, input logic [15:0] ca, input logic [7:0] cw,
                      input logic [7:0] pg, input logic [5:0] vl, input string tag);
    logic [7:0] hp, cp, eh, ec;
    logic       erst, enmi, nd, nc;
    hp = ha[7:0]; cp = ca[7:0];
    h_addr = ha; h_wdata = hw; h_wr = (hop == OP_WR); h_rd = (hop == OP_RD);
    c_addr = ca; c_wdata = cw; c_wr = (cop == OP_WR); c_rd = (cop == OP_RD);
    page_in = pg; vol_in = vl;
    eh = (hop == OP_RD) ? host_exp(hp) : last_h;
    ec = (cop == OP_RD) ? cop_exp(cp) : last_c;
    erst = (hop == OP_WR) && hp == 8'h33 && hw[7];
    enmi = (hop == OP_WR) && hp == 8'h33 && !hw[7] && hw[6];
    @(posedge clk); #1;
    check((tag != "") ? tag : ((hop == OP_RD) ? host_tag(hp) : "R11"), h_rdata, eh);
    check((tag != "") ? tag : ((cop == OP_RD) ? cop_tag(cp) : "R11"), c_rdata, ec);
    check("R4", {6'd0, core_rst_pulse, core_nmi_pulse}, {6'd0, erst, enmi});
    last_h = eh; last_c = ec;
    nd = m_d; nc = m_c;
    if (hop == OP_WR && hp == 8'hB3) begin m_out = hw; nd = 1'b1; end
    if (hop == OP_WR && hp == 8'hBB) begin m_cmd = hw; nc = 1'b1; end
    if (hop == OP_RD && hp == 8'hB3) nd = 1'b0;
    if (cop != OP_NONE) begin
      if (cp == 8'h02) nd = 1'b0;
      if (cp == 8'h03) begin nd = 1'b1; m_in = (cop == OP_WR) ? cw : 8'hFF; end
      if (cp == 8'h0A) nd = pg[0];
      if (cp == 8'h05) nc = 1'b0;
      if (cp == 8'h0B) nc = vl[5];
    end
    m_d = nd; m_c = nc;
    h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick_addr(input bit host);
    logic [7:0] lo;
    int k;
    k = $urandom_range(0, 9);
    if (host) lo = (k < 3) ? 8'hB3 : (k < 6) ? 8'hBB : (k < 7) ? 8'h33 : 8'($urandom);
    else begin
      case (k)
        0: lo = 8'h01; 1: lo = 8'h02; 2: lo = 8'h03; 3: lo = 8'h04;
        4: lo = 8'h05; 5: lo = 8'h0A; 6: lo = 8'h0B; 7: lo = 8'h04;
        default: lo = 8'($urandom);
      endcase
    end
    return {8'($urandom), lo};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    h_addr = 0; c_addr = 0; h_wdata = 0; c_wdata = 0;
    h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0; page_in = 0; vol_in = 0;
    m_cmd = 0; m_out = 0; m_in = 0; m_d = 0; m_c = 0; last_h = 0; last_c = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1", h_rdata, 8'h00);
    check("R1", c_rdata, 8'h00);
    check("R1", {6'd0, core_rst_pulse, core_nmi_pulse}, 8'h00);
    @(negedge clk);
    step(OP_RD, 16'h00BB, 0, OP_RD, 16'h0004, 0, 0, 0, "R1");
    step(OP_RD, 16'h00B3, 0, OP_RD, 16'h0001, 0, 0, 0, "R1");
    // R2 data and command from the host, seen by the coprocessor
    step(OP_WR, 16'h12B3, 8'hA5, OP_NONE, 0, 0, 0, 0, "R2");
    step(OP_WR, 16'h00BB, 8'h3C, OP_RD, 16'h0004, 0, 0, 0, "R2");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R2");
    step(OP_NONE, 0, 0, OP_RD, 16'h0001, 0, 0, 0, "R2");
    // R6 outbound read clears bit 7; R11 pre-state returned
    step(OP_NONE, 0, 0, OP_RD, 16'hFF02, 0, 0, 0, "R6");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R6");
    step(OP_NONE, 0, 0, OP_NONE, 0, 0, 0, 0, "R11");
    // R7 inbound from the coprocessor, then host collects
    step(OP_NONE, 0, 0, OP_WR, 16'h0003, 8'h5A, 0, 0, "R7");
    step(OP_RD, 16'h00BB, 0, OP_NONE, 0, 0, 0, 0, "R7");
    step(OP_RD, 16'h00B3, 0, OP_NONE, 0, 0, 0, 0, "R3");
    step(OP_RD, 16'h00BB, 0, OP_RD, 16'h0003, 0, 0, 0, "R7");
    step(OP_RD, 16'h00B3, 0, OP_WR, 16'h0002, 8'h00, 0, 0, "R7");
    // R8 any access to port 0x05
    step(OP_NONE, 0, 0, OP_WR, 16'h0005, 8'h77, 0, 0, "R8");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R8");
    // R9 page and volume copies
    step(OP_NONE, 0, 0, OP_RD, 16'h000A, 0, 8'h01, 6'h00, "R9");
    step(OP_NONE, 0, 0, OP_WR, 16'h000B, 8'h00, 8'h00, 6'h20, "R9");
    step(OP_RD, 16'h00BB, 0, OP_NONE, 0, 0, 0, 0, "R9");
    step(OP_NONE, 0, 0, OP_RD, 16'h000A, 0, 8'hFE, 6'h1F, "R9");
    step(OP_NONE, 0, 0, OP_RD, 16'h000B, 0, 8'hFE, 6'h1F, "R9");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R9");
    // R4 control pulses
    step(OP_WR, 16'h0033, 8'hC0, OP_NONE, 0, 0, 0, 0, "R4");
    step(OP_WR, 16'h4433, 8'h40, OP_NONE, 0, 0, 0, 0, "R4");
    step(OP_WR, 16'h0033, 8'h3F, OP_NONE, 0, 0, 0, 0, "R4");
    // R10 unmapped ports and high address bits
    step(OP_RD, 16'h0033, 0, OP_RD, 16'h0077, 0, 0, 0, "R10");
    step(OP_RD, 16'hB300, 0, OP_RD, 16'h0400, 0, 0, 0, "R10");
    // R12 same-cycle conflicts
    step(OP_WR, 16'h00B3, 8'h11, OP_RD, 16'h0002, 0, 0, 0, "R12");
    step(OP_WR, 16'h00BB, 8'h22, OP_WR, 16'h0005, 0, 0, 0, "R12");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R12");
    step(OP_WR, 16'h00BB, 8'h23, OP_RD, 16'h000B, 0, 0, 6'h00, "R12");
    step(OP_RD, 16'h00B3, 0, OP_RD, 16'h000A, 0, 8'h01, 0, "R12");
    step(OP_NONE, 0, 0, OP_RD, 16'h0004, 0, 0, 0, "R12");
    // random traffic on both sides
    for (int i = 0; i < 3000; i++) begin
      step(int'($urandom_range(0, 2)), pick_addr(1'b1), 8'($urandom),
           int'($urandom_range(0, 2)), pick_addr(1'b0), 8'($urandom),
           8'($urandom), 6'($urandom), "");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule